// File: doc/BRIEF.md
# Register Write-Protect Unlock Sequencer

This block guards a small byte-wide register space behind a status register holding two enable latches. A host writes bytes through a burst port: a burst opens with a two-byte address (the high byte must be zero), every data byte then lands at the next consecutive address, and a stop marks the end of the burst. Register contents can be read back at any time through a combinational read port.

Writes to any register other than the status register take effect only after a two-step unlock. The host first writes the arm code, which sets the first latch alone. It then writes the open code, which sets both latches. Writing zero to the status register locks the space again. The lower part of the space models a nonvolatile area. A burst that stored any byte there starts a busy period when it stops. The period is counted in pulses of a slow tick input. While it runs, every write is refused. When it ends, the second latch drops, so the host has to open the space again before its next write.

Top module: `wp_unlock_seq`

## Requirements
- R1: After reset both latches are clear, busy is low, and every address reads 0x00.
- R2: Writing 0x02 to the status register (address 0x3F) sets the first latch alone, so the status reads 0x02.
- R3: Writing 0x06 to the status register sets both latches only when the first latch is already set. From the locked state, 0x06 sets neither latch and the status keeps reading 0x00.
- R4: Writing 0x00 to the status register clears both latches. Later writes to other registers are then ignored.
- R5: While the space is not fully open (status other than 0x06), a write to any register other than the status register is ignored, and the register keeps its value.
- R6: With the space open, the bytes of one burst are stored at consecutive addresses, starting at the burst's address.
- R7: A burst whose high address byte is non-zero stores nothing, and this includes status writes.
- R8: Stopping a burst that stored a byte below address 0x30 raises busy for exactly NV_TICKS tick pulses. When busy falls, the second latch is cleared (the status reads 0x02), and a data write made before the space is reopened is ignored.
- R9: While busy is high, every written byte is ignored, whether it is a status write or a data write.
- R10: A burst that stores bytes only in 0x30..0x3E leaves busy low and the space open.
- R11: Status values other than 0x00, 0x02 and 0x06 leave the latches unchanged. Status bits 7:3 and bit 0 always read zero.
- R12: Addresses above 0x3F read as 0x00, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle pulse that paces the nonvolatile busy period |
| cmd_start | input | 1 | Opens a burst and loads the address |
| addr_hi | input | 8 | First address byte; must be zero for the burst to store anything |
| addr_lo | input | 8 | Register address where the burst starts |
| dat_we | input | 1 | Writes wr_byte at the current pointer, then advances the pointer |
| wr_byte | input | 8 | Write data byte |
| cmd_stop | input | 1 | Ends the burst and may start the busy period |
| rd_addr | input | 8 | Read address |
| rd_data | output | 8 | Read data; the status register reads {5'b0, second latch, first latch, 1'b0} |
| busy | output | 1 | High while the nonvolatile busy period runs |

## Verification
The assertions take for granted that tick, cmd_start, dat_we and cmd_stop are single-cycle strobes. They also assume that a start, a data byte and a stop never share a cycle, because the block gives a start priority and would otherwise drop the byte. The bench tasks raise exactly one strobe for one cycle and release it before the next. Every byte of a burst is therefore seen once, and every tick moves the busy counter by exactly one step.

// File: rtl/wp_unlock_pkg.sv
package wp_unlock_pkg;

    localparam logic [7:0] ST_CODE_LOCK = 8'h00;
    localparam logic [7:0] ST_CODE_ARM  = 8'h02;
    localparam logic [7:0] ST_CODE_OPEN = 8'h06;

    typedef enum logic [1:0] {
        STC_NONE = 2'd0,
        STC_LOCK = 2'd1,
        STC_ARM  = 2'd2,
        STC_OPEN = 2'd3
    } st_cmd_e;

    function automatic st_cmd_e decode_status(input logic [7:0] v);
        st_cmd_e c;
        case (v)
            ST_CODE_LOCK: c = STC_LOCK;
            ST_CODE_ARM:  c = STC_ARM;
            ST_CODE_OPEN: c = STC_OPEN;
            default:      c = STC_NONE;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/wp_latch_ctl.sv
module wp_latch_ctl
    import wp_unlock_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    cmd_vld,
    input  st_cmd_e cmd,
    input  logic    nv_done,
    output logic    wel,
    output logic    rwel
);

    typedef struct packed {
        logic wel;
        logic rwel;
    } lat_t;

    lat_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (nv_done) begin
            s_d.rwel = 1'b0;
        end
        if (cmd_vld) begin
            case (cmd)
                STC_LOCK: begin
                    s_d.wel  = 1'b0;
                    s_d.rwel = 1'b0;
                end
                STC_ARM: begin
                    s_d.wel  = 1'b1;
                    s_d.rwel = 1'b0;
                end
                STC_OPEN: begin
                    if (s_q.wel) begin
                        s_d.wel  = 1'b1;
                        s_d.rwel = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign wel  = s_q.wel;
    assign rwel = s_q.rwel;

endmodule

// File: rtl/wp_nv_timer.sv
module wp_nv_timer #(
    parameter int NV_TICKS = 10,
    localparam int CNT_W   = $clog2(NV_TICKS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             tick,
    output logic             busy,
    output logic             done,
    output logic [CNT_W-1:0] count
);

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t s_d, s_q;
    logic last_tick;

    assign last_tick = s_q.busy && tick && (s_q.cnt == CNT_W'(1));

    always_comb begin
        s_d = s_q;
        if (!s_q.busy) begin
            if (start) begin
                s_d.busy = 1'b1;
                s_d.cnt  = CNT_W'(NV_TICKS);
            end
        end else if (tick) begin
            if (last_tick) begin
                s_d.busy = 1'b0;
                s_d.cnt  = '0;
            end else begin
                s_d.cnt = s_q.cnt - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy  = s_q.busy;
    assign done  = last_tick;
    assign count = s_q.cnt;

endmodule

// File: rtl/wp_regfile.sv
module wp_regfile #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 8,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] mem;
    } rf_t;

    rf_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        for (int i = 0; i < DEPTH; i++) begin
            if (we && (waddr == ADDR_W'(i))) begin
                s_d.mem[i] = wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rdata = s_q.mem[raddr];

endmodule

// File: rtl/wp_unlock_seq.sv
module wp_unlock_seq
    import wp_unlock_pkg::*;
#(
    parameter int         ADDR_W   = 6,
    parameter logic [7:0] NV_LIMIT = 8'h30,
    parameter int         NV_TICKS = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       cmd_start,
    input  logic [7:0] addr_hi,
    input  logic [7:0] addr_lo,
    input  logic       dat_we,
    input  logic [7:0] wr_byte,
    input  logic       cmd_stop,
    input  logic [7:0] rd_addr,
    output logic [7:0] rd_data
,   output logic       busy
);

    localparam int         DEPTH     = 1 << ADDR_W;
    localparam logic [7:0] STAT_ADDR = 8'(DEPTH - 1);
    localparam int         CNT_W     = $clog2(NV_TICKS + 1);

    typedef struct packed {
        logic [7:0] ptr;
        logic       ptr_ok;
        logic       nv_hit;
    } seq_t;

    seq_t s_d, s_q;

    logic             lat_wel, lat_rwel;
    logic             nv_done, nv_start;
    logic [CNT_W-1:0] nv_cnt;
    logic             in_range, byte_live, st_wr, data_ok, nv_byte;
    logic [7:0]       st_val;
    logic [7:0]       rf_rdata;

    assign in_range  = (s_q.ptr < 8'(DEPTH));
    assign byte_live = dat_we && !cmd_start && s_q.ptr_ok && in_range && !busy;
    assign st_wr     = byte_live && (s_q.ptr == STAT_ADDR);
    assign st_val    = wr_byte;
    assign data_ok   = byte_live && !st_wr && lat_wel && lat_rwel;
    assign nv_byte   = data_ok && (s_q.ptr < NV_LIMIT);
    assign nv_start  = cmd_stop && !cmd_start && (s_q.nv_hit || nv_byte);

    always_comb begin
        s_d = s_q;
        if (cmd_start) begin
            s_d.ptr    = addr_lo;
            s_d.ptr_ok = (addr_hi == 8'h00);
            s_d.nv_hit = 1'b0;
        end else begin
            if (dat_we) begin
                s_d.ptr = s_q.ptr + 8'd1;
                if (s_q.ptr == 8'hFF) begin
                    s_d.ptr_ok = 1'b0;
                end
                if (nv_byte) begin
                    s_d.nv_hit = 1'b1;
                end
            end
            if (cmd_stop) begin
                s_d.nv_hit = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    wp_latch_ctl u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmd_vld (st_wr),
        .cmd     (decode_status(st_val)),
        .nv_done (nv_done),
        .wel     (lat_wel),
        .rwel    (lat_rwel)
    );

    wp_nv_timer #(
        .NV_TICKS (NV_TICKS)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (nv_start),
        .tick  (tick),
        .busy  (busy),
        .done  (nv_done),
        .count (nv_cnt)
    );

    wp_regfile #(
        .ADDR_W (ADDR_W),
        .DATA_W (8)
    ) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (data_ok),
        .waddr (s_q.ptr[ADDR_W-1:0]),
        .wdata (wr_byte),
        .raddr (rd_addr[ADDR_W-1:0]),
        .rdata (rf_rdata)
    );

    always_comb begin
        if (rd_addr >= 8'(DEPTH)) begin
            rd_data = 8'h00;
        end else if (rd_addr == STAT_ADDR) begin
            rd_data = {5'b0, lat_rwel, lat_wel, 1'b0};
        end else begin
            rd_data = rf_rdata;
        end
    end

endmodule

// File: rtl/wp_unlock_chk.sv
module wp_unlock_chk #(
    parameter int NV_TICKS = 10,
    parameter int CNT_W    = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             cmd_stop,
    input logic             busy,
    input logic             wel,
    input logic             rwel,
    input logic             st_wr,
    input logic [7:0]       st_val,
    input logic [CNT_W-1:0] nv_cnt
);

    AST_RWEL_IMPLIES_WEL: assert property (@(posedge clk) disable iff (!rst_n)
        rwel |-> wel); // R3

    AST_RWEL_RISE_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rwel) |-> $past(wel)); // R3

    AST_LOCK_ON_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (st_wr && st_val == 8'h00) |=> (!wel && !rwel)); // R4

    AST_BUSY_FREEZES_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tick) |=> ($stable(wel) && $stable(rwel))); // R9

    AST_BUSY_END_DROPS_RWEL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !rwel); // R8

    AST_BUSY_RISE_ON_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(cmd_stop)); // R8

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (nv_cnt != '0 && nv_cnt <= CNT_W'(NV_TICKS))); // R8

endmodule

bind wp_unlock_seq wp_unlock_chk #(
    .NV_TICKS (NV_TICKS),
    .CNT_W    (CNT_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .cmd_stop (cmd_stop),
    .busy     (busy),
    .wel      (lat_wel),
    .rwel     (lat_rwel),
    .st_wr    (st_wr),
    .st_val   (st_val),
    .nv_cnt   (nv_cnt)
);

// File: tb/wp_unlock_seq_tb.sv
module wp_unlock_seq_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NV_TICKS   = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       cmd_start = 1'b0;
    logic [7:0] addr_hi = 8'h00;
    logic [7:0] addr_lo = 8'h00;
    logic       dat_we = 1'b0;
    logic [7:0] wr_byte = 8'h00;
    logic       cmd_stop = 1'b0;
    logic [7:0] rd_addr = 8'h00;
    logic [7:0] rd_data;
    logic       busy;

    int n_chk = 0;
    int n_err = 0;
    int cycles = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    wp_unlock_seq #(.NV_TICKS(NV_TICKS)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .cmd_start (cmd_start),
        .addr_hi   (addr_hi),
        .addr_lo   (addr_lo),
        .dat_we    (dat_we),
        .wr_byte   (wr_byte),
        .cmd_stop  (cmd_stop),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .busy      (busy)
    );

    function automatic logic [7:0] pat_ccr(input int a);
        return 8'((a * 13 + 5) & 8'hFF);
    endfunction

    function automatic logic [7:0] pat_nv(input int a);
        return 8'((a * 29 + 71) & 8'hFF);
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] v);
        @(negedge clk);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic chk_rd(input string req, input logic [7:0] a, input logic [7:0] exp);
        logic [7:0] v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    task automatic begin_burst(input logic [7:0] hi, input logic [7:0] lo);
        @(negedge clk);
        cmd_start = 1'b1; addr_hi = hi; addr_lo = lo;
        @(negedge clk);
        cmd_start = 1'b0;
    endtask

    task automatic put(input logic [7:0] b);
        @(negedge clk);
        dat_we = 1'b1; wr_byte = b;
        @(negedge clk);
        dat_we = 1'b0;
    endtask

    task automatic end_burst();
        @(negedge clk);
        cmd_stop = 1'b1;
        @(negedge clk);
        cmd_stop = 1'b0;
    endtask

    task automatic wr1(input logic [7:0] a, input logic [7:0] b);
        begin_burst(8'h00, a);
        put(b);
        end_burst();
    endtask

    task automatic pulse_tick();
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                n_err++; n_chk++;
                $display("FAIL watchdog: actual=%0d expected<=100000", cycles);
                $display("Result: errors=%0d of %0d checks", n_err, n_chk);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 / R12: reset state over the whole address byte range
        for (int a = 0; a < 256; a++) chk_rd("R1", 8'(a), 8'h00);
        chk("R1", {7'b0, busy}, 8'h00);

        // R5: locked write ignored
        wr1(8'h31, 8'h55);
        chk_rd("R5", 8'h31, 8'h00);
        // R3: open code from locked state sets nothing
        wr1(8'h3F, 8'h06);
        chk_rd("R3", 8'h3F, 8'h00);
        // R2: arm code
        wr1(8'h3F, 8'h02);
        chk_rd("R2", 8'h3F, 8'h02);
        // R5: armed only, data write ignored
        wr1(8'h31, 8'h55);
        chk_rd("R5", 8'h31, 8'h00);
        // R3: open after arm
        wr1(8'h3F, 8'h06);
        chk_rd("R3", 8'h3F, 8'h06);
        // R11: unknown codes leave latches, reserved bits zero
        wr1(8'h3F, 8'hFF);
        chk_rd("R11", 8'h3F, 8'h06);
        wr1(8'h3F, 8'h04);
        chk_rd("R11", 8'h3F, 8'h06);

        // R6 / R10: burst across 0x30..0x3E
        begin_burst(8'h00, 8'h30);
        for (int a = 8'h30; a < 8'h3F; a++) put(pat_ccr(a));
        end_burst();
        for (int a = 8'h30; a < 8'h3F; a++) chk_rd("R6", 8'(a), pat_ccr(a));
        chk("R10", {7'b0, busy}, 8'h00);
        chk_rd("R10", 8'h3F, 8'h06);

        // R7: non-zero high address byte stores nothing
        begin_burst(8'h01, 8'h32);
        put(8'hA5);
        end_burst();
        chk_rd("R7", 8'h32, pat_ccr(8'h32));
        begin_burst(8'h80, 8'h3F);
        put(8'h00);
        end_burst();
        chk_rd("R7", 8'h3F, 8'h06);

        // R12: out-of-range address ignored and no alias
        wr1(8'h50, 8'h77);
        chk_rd("R12", 8'h50, 8'h00);
        chk_rd("R12", 8'h10, 8'h00);

        // R6 / R8: nonvolatile burst 0x00..0x2F
        begin_burst(8'h00, 8'h00);
        for (int a = 0; a < 8'h30; a++) put(pat_nv(a));
        end_burst();
        chk("R8", {7'b0, busy}, 8'h01);
        // R9: writes during busy are ignored
        wr1(8'h3F, 8'h00);
        wr1(8'h31, 8'hAA);
        chk_rd("R9", 8'h31, pat_ccr(8'h31));
        for (int t = 1; t < NV_TICKS; t++) pulse_tick();
        chk("R8", {7'b0, busy}, 8'h01);
        pulse_tick();
        chk("R8", {7'b0, busy}, 8'h00);
        chk_rd("R9", 8'h3F, 8'h02);
        for (int a = 0; a < 8'h30; a++) chk_rd("R6", 8'(a), pat_nv(a));

        // R8: second latch must be set again
        wr1(8'h35, 8'h11);
        chk_rd("R8", 8'h35, pat_ccr(8'h35));
        wr1(8'h3F, 8'h06);
        chk_rd("R3", 8'h3F, 8'h06);
        wr1(8'h35, 8'h11);
        chk_rd("R6", 8'h35, 8'h11);

        // R4: lock, then writes ignored
        wr1(8'h3F, 8'h00);
        chk_rd("R4", 8'h3F, 8'h00);
        wr1(8'h36, 8'h99);
        chk_rd("R4", 8'h36, pat_ccr(8'h36));
        wr1(8'h05, 8'h99);
        chk_rd("R4", 8'h05, pat_nv(8'h05));
        chk("R4", {7'b0, busy}, 8'h00);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule